// File: doc/BRIEF.md
# Serial/Parallel FIFO Entry Stage

This block is the front end of a 4-bit-wide FIFO slice that can be chained with other slices. A word arrives either in one parallel load or as four bits on a serial line. Once the word is complete, an active-low full flag drops. When the downstream stack signals that its top location is free and a transfer is requested, the block writes the held word into the stack exactly once. It then re-initializes so that it can accept the next word.

Word completion is detected with a fifth marker bit. Initialization leaves a one in the top data position. Serial shifting moves that one down toward the marker, and it reaches the marker on the fourth shift. A master/slave interlock controls chained slices. A master slice re-initializes as soon as the parallel load is released. A slave slice waits until its chain input, driven by the full flag of the slice ahead of it, goes low. All pins are sampled on the rising edge of one system clock, and the serial clock is treated as a sampled signal whose falling edge is detected.

Top module: `fifo_entry_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block initializes. After reset, `full_n` is 1, `stack_wr` is 0 and `stack_wdata` is 4'b1000, with the top data bit set and the others clear.
- R2: When `par_load` is 1 at a clock edge, `par_din` is copied into the data bits and the word is marked complete, so `full_n` is 0 after that edge.
- R3: A serial falling edge is detected when `ser_clk` is sampled 1 at one clock edge and 0 at the next. At such an edge, if `chain_en_n`, `par_load` and the marker are all 0, `ser_din` enters bit 3 and the other bits move down one place. After four shifts the first bit sits in bit 0, the fourth bit sits in bit 3, and `full_n` goes to 0.
- R4: While `full_n` is 0, further serial edges leave `stack_wdata` unchanged.
- R5: Serial edges while `chain_en_n` is 1 have no effect on `stack_wdata` or `full_n`.
- R6: `stack_wr` is 1, with `stack_wdata` carrying the held word, when `xfer_n` is 0, `full_n` is 0, `stack_top_empty` is 1, and this word has not been written yet. Each word produces exactly one write cycle, even if `xfer_n` stays low.
- R7: No write occurs while `stack_top_empty` is 0. The write takes place once it becomes 1.
- R8: After a write, re-initialization to the R1 state happens at the first clock edge, following the write edge, at which `par_load` is 0 and the slice is allowed to proceed (see R9). While `par_load` stays 1, `full_n` remains 0.
- R9: The slice becomes a master if `chain_en_n` is 0 while in reset, and a slave otherwise. A master re-initializes without regard to `chain_en_n`. A slave re-initializes only at an edge where `chain_en_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also captures the master/slave role |
| par_load | input | 1 | Parallel load, active high |
| par_din | input | 4 | Parallel data word |
| ser_clk | input | 1 | Serial bit clock, acts on its falling edge |
| ser_din | input | 1 | Serial data bit |
| chain_en_n | input | 1 | Chain enable, active low; tie to 0 on a master, or drive from the full flag of the slice ahead |
| xfer_n | input | 1 | Transfer request, active low |
| stack_top_empty | input | 1 | Top location of the stack is free |
| full_n | output | 1 | Word held, active low |
| stack_wr | output | 1 | Write strobe to the stack |
| stack_wdata | output | 4 | Held word, driven to the stack |

## Verification
Two actions can meet in the same cycle: a stack write and a parallel load that is still asserted. The bench keeps `par_load` high while the transfer request is active and the stack top is free. It then checks that exactly one write strobe appears, carrying the loaded word, and that `full_n` stays low until the load is released. A second case holds back the slave's re-initialization behind its chain input while `xfer_n` remains low. The bench checks that no second write of the same word occurs.

// File: rtl/fifo_entry_stage.sv
module fifo_entry_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         par_load,
  input  logic [W-1:0] par_din,
  input  logic         ser_clk,
  input  logic         ser_din,
  input  logic         chain_en_n,
  input  logic         xfer_n,
  input  logic         stack_top_empty,
  output logic         full_n,
  output logic         stack_wr,
  output logic [W-1:0] stack_wdata
);

  localparam logic [W-1:0] INIT_WORD = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] dat;
  logic         mark, req, master, sclk_q;

  wire sfall   = sclk_q & ~ser_clk;
  wire init_go = req & ~par_load & (master | ~chain_en_n);

  assign full_n      = ~mark;
  assign stack_wdata = dat;
  assign stack_wr    = ~xfer_n & mark & stack_top_empty & ~req;

  always_ff @(posedge clk) begin
    sclk_q <= ser_clk;
    if (!rst_n) begin
      dat    <= INIT_WORD;
      mark   <= 1'b0;
      req    <= 1'b0;
      master <= ~chain_en_n;
    end else begin
      if (stack_wr)     req <= 1'b1;
      else if (init_go) req <= 1'b0;

      if (init_go) begin
        dat  <= INIT_WORD;
        mark <= 1'b0;
      end else if (par_load) begin
        dat  <= par_din;
        mark <= 1'b1;
      end else if (sfall && !chain_en_n && !mark) begin
        {dat, mark} <= {ser_din, dat};
      end
    end
  end

  // R6
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_wr |=> !stack_wr);

  // R2
  fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_n) |-> $past(par_load || (sfall && !chain_en_n)));

  // R8
  reinit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_n) |-> $past(req && !par_load));

  // R9
  slave_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full_n) && !master) |-> $past(!chain_en_n));

  // R4
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !req && !par_load) |=> $stable(stack_wdata));

endmodule

// File: tb/fifo_entry_stage_bench.sv
module fifo_entry_stage_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, par_load = 0, ser_clk = 0, ser_din = 0;
  logic chain_en_n = 0, xfer_n = 1, stack_top_empty = 0;
  logic [3:0] par_din = 0;
  logic full_n, stack_wr;
  logic [3:0] stack_wdata;
  int tests = 0, failed = 0, wr_cnt = 0;

  fifo_entry_stage u_fifo_entry_stage (
    .clk(clk), .rst_n(rst_n), .par_load(par_load), .par_din(par_din),
    .ser_clk(ser_clk), .ser_din(ser_din), .chain_en_n(chain_en_n),
    .xfer_n(xfer_n), .stack_top_empty(stack_top_empty),
    .full_n(full_n), .stack_wr(stack_wr), .stack_wdata(stack_wdata));

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && stack_wr) wr_cnt++;

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset(input logic slave);
    @(negedge clk);
    rst_n = 0; chain_en_n = slave; par_load = 0; xfer_n = 1;
    ser_clk = 0; stack_top_empty = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    @(negedge clk); ser_din = b; ser_clk = 1;
    @(negedge clk); ser_clk = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(0);
    chk("R1 full_n", full_n, 1);
    chk("R1 wdata", stack_wdata, 4'h8);
    chk("R1 stack_wr", stack_wr, 0);
  endtask

  task automatic t_disabled;
    chain_en_n = 1;
    ser_bit(1'b0);
    chk("R5 wdata", stack_wdata, 4'h8);
    chk("R5 full_n", full_n, 1);
    chain_en_n = 0;
  endtask

  task automatic t_serial;
    ser_bit(0); ser_bit(1); ser_bit(0);
    chk("R3 not full after 3", full_n, 1);
    ser_bit(1);
    chk("R3 full after 4", full_n, 0);
    chk("R3 word", stack_wdata, 4'hA);
    ser_bit(0);
    chk("R4 extra edge ignored", stack_wdata, 4'hA);
  endtask

  task automatic t_transfer_master;
    int c0;
    c0 = wr_cnt;
    @(negedge clk); xfer_n = 0; stack_top_empty = 0;
    #1 chk("R7 no write when top busy", stack_wr, 0);
    repeat (2) @(negedge clk);
    chk("R7 still no write", wr_cnt - c0, 0);
    stack_top_empty = 1;
    #1 chk("R6 write strobe", stack_wr, 1);
    chk("R6 write data", stack_wdata, 4'hA);
    repeat (4) @(negedge clk);
    chk("R6 one write per word", wr_cnt - c0, 1);
    chk("R8 reinit full_n", full_n, 1);
    chk("R8 reinit word", stack_wdata, 4'h8);
    xfer_n = 1; stack_top_empty = 0;
  endtask

  task automatic t_par_hold;
    int c0;
    c0 = wr_cnt;
    @(negedge clk); par_load = 1; par_din = 4'h5; xfer_n = 0; stack_top_empty = 1;
    @(negedge clk);
    chk("R2 full after load", full_n, 0);
    chk("R2 loaded word", stack_wdata, 4'h5);
    repeat (4) @(negedge clk);
    chk("R8 held while load high", full_n, 0);
    chk("R6 single write under load", wr_cnt - c0, 1);
    par_load = 0;
    repeat (2) @(negedge clk);
    chk("R8 reinit after release", full_n, 1);
    xfer_n = 1; stack_top_empty = 0;
  endtask

  task automatic t_slave;
    int c0;
    do_reset(1);
    c0 = wr_cnt;
    par_din = 4'h3; par_load = 1;
    @(negedge clk); par_load = 0;
    chk("R2 slave load", stack_wdata, 4'h3);
    xfer_n = 0; stack_top_empty = 1;
    repeat (5) @(negedge clk);
    chk("R9 slave waits", full_n, 0);
    chk("R6 slave single write", wr_cnt - c0, 1);
    chain_en_n = 0;
    repeat (2) @(negedge clk);
    chk("R9 slave reinit", full_n, 1);
    chk("R9 slave word", stack_wdata, 4'h8);
    xfer_n = 1;
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_serial();
    t_transfer_master();
    t_par_hold();
    t_slave();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule